// File: doc/BRIEF.md
# I2C Bus Phase Timer

This block turns symbolic bus requests from a byte engine into correctly timed SCL and SDA levels for an I2C master. The engine asks for one of four things: a START (which becomes a repeated START when the bus is already held), a bit to send, a bit to receive, or a STOP. When the request is finished, the block returns a one-cycle done pulse and, for a receive, the sampled bit. Between requests the block holds SCL low, so the engine can take as long as it needs.

Every bus phase has its own duration field in four 32-bit configuration words. A shared prescaler scales all of these fields. Both bus inputs pass through a programmable glitch filter. SCL high time is counted only after the filtered SCL is seen high, so a target that holds SCL low stretches the clock. The outputs are open-drain intents: a 1 means release the line and a 0 means pull it low.

Top module: `i2c_phase_timer`

## Requirements
- R1: After reset, scl_o and sda_o are 1, bus_idle and req_ready are 1, and done is 0.
- R2: Let U = prescale+1, where prescale is bits 23:16 of cfg_prescale. A phase with count N lasts N·U cycles, or 1 cycle when N is 0. For a START (req_op=0) accepted in idle, sda_o falls dur(start setup, cfg_start_stop[31:24]) cycles after acceptance while scl_o is 1. After a further dur(start hold, cfg_start_stop[23:16]) cycles, scl_o falls and done pulses.
- R3: For a send bit (req_op=1), sda_o takes req_bit dur(data hold, cfg_hold[7:0]) cycles after acceptance. scl_o rises after a further dur(low, cfg_bit[15:8]) + dur(data setup, cfg_bit[31:24]) cycles.
- R4: With no stretching and filter count F (cfg_filter), scl_o stays high for F+2+dur(high, cfg_bit[7:0]) cycles. It then falls in the same cycle that done pulses.
- R5: If the target holds SCL low for S extra cycles after release, the high phase and done are delayed by exactly S cycles.
- R6: A receive bit (req_op=2) releases sda_o after the data hold phase. rx_bit shows the filtered SDA level taken in the last cycle of the high phase, and it is valid when done pulses.
- R7: A STOP (req_op=3) drives sda_o low after the data hold phase and releases SCL after the data setup phase. Once SCL is seen high and dur(stop setup, cfg_start_stop[15:8]) cycles have passed, sda_o rises, done pulses and bus_idle is 1.
- R8: A START accepted while the bus is held first releases sda_o with SCL low for dur(release, cfg_prescale[7:0]) cycles. It then releases SCL, waits F+2 cycles for it, and continues with the START timing of R2.
- R9: In idle, requests other than START are ignored: scl_o and sda_o stay 1, no done appears and bus_idle stays 1.
- R10: A filtered input takes a new level only after F+1 consecutive equal samples. A one-cycle high glitch on SCL during a stretch does not shorten it.
- R11: done is a single-cycle pulse and appears only when req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start_stop | input | 32 | Start setup [31:24], start hold [23:16], stop setup [15:8] |
| cfg_bit | input | 32 | Data setup [31:24], low [15:8], high [7:0] |
| cfg_prescale | input | 32 | Prescaler [23:16], repeated-start release [7:0] |
| cfg_hold | input | 32 | Data hold [7:0] |
| cfg_filter | input | 3 | Glitch filter count F |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 start, 1 send, 2 receive, 3 stop |
| req_bit | input | 1 | Bit to send |
| req_ready | output | 1 | Idle or holding; request accepted this cycle |
| done | output | 1 | Request finished pulse |
| rx_bit | output | 1 | Received bit |
| bus_idle | output | 1 | Bus released after STOP |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_o | output | 1 | SCL drive (0 pulls low) |
| sda_o | output | 1 | SDA drive (0 pulls low) |

## Verification
On every cycle, the assertions check the following line rules: SDA never changes on a rising SCL edge, a falling SDA while SCL is high happens only inside a START, and a rising SDA while SCL is high puts the bus in idle. They also check that done is a one-cycle pulse and that requests in idle other than START are ignored. Exact phase lengths cannot be seen one cycle at a time, so only the bench scenarios show them. The same goes for the stretching delay, glitch rejection and the received bit values. The bench measures these across a sweep of prescaler and filter settings.

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_start_stop,
  input  logic [31:0] cfg_bit,
  input  logic [31:0] cfg_prescale,
  input  logic [31:0] cfg_hold,
  input  logic [2:0]  cfg_filter,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic        req_bit,
  output logic        req_ready,
  output logic        done,
  output logic        rx_bit,
  output logic        bus_idle,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_o,
  output logic        sda_o
);
  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [3:0] {
    IDLE, S_SU, S_HD, HOLD, R_REL, R_WT,
    B_HD, B_LO, B_SU, B_WT, B_HI, P_HD, P_LO, P_WT, P_SU
  } st_t;

  st_t st, nxt;
  logic [7:0] pc, tc, n;
  logic [1:0] filt;
  logic [2:0] fcnt [2];
  logic sda_r, wbit, rd, fin, timed_fin;

  wire [7:0] presc = cfg_prescale[23:16];
  wire [1:0] raw = {sda_i, scl_i};
  wire scl_f = filt[0];
  wire sda_f = filt[1];

  always_comb begin
    case (st)
      S_SU:       n = cfg_start_stop[31:24];
      S_HD:       n = cfg_start_stop[23:16];
      P_SU:       n = cfg_start_stop[15:8];
      B_SU, P_LO: n = cfg_bit[31:24];
      B_LO:       n = cfg_bit[15:8];
      B_HI:       n = cfg_bit[7:0];
      R_REL:      n = cfg_prescale[7:0];
      B_HD, P_HD: n = cfg_hold[7:0];
      default:    n = 8'd0;
    endcase
  end

  assign timed_fin = (n == 8'd0) || (pc == presc && ({1'b0, tc} + 9'd1) == {1'b0, n});
  assign fin = (st inside {R_WT, B_WT, P_WT}) ? scl_f : timed_fin;

  always_comb begin
    nxt = st;
    case (st)
      IDLE: if (req_valid && req_op == OP_START) nxt = S_SU;
      HOLD: if (req_valid) begin
        case (req_op)
          OP_START: nxt = R_REL;
          OP_STOP:  nxt = P_HD;
          default:  nxt = B_HD;
        endcase
      end
      S_SU:  if (fin) nxt = S_HD;
      S_HD:  if (fin) nxt = HOLD;
      R_REL: if (fin) nxt = R_WT;
      R_WT:  if (fin) nxt = S_SU;
      B_HD:  if (fin) nxt = B_LO;
      B_LO:  if (fin) nxt = B_SU;
      B_SU:  if (fin) nxt = B_WT;
      B_WT:  if (fin) nxt = B_HI;
      B_HI:  if (fin) nxt = HOLD;
      P_HD:  if (fin) nxt = P_LO;
      P_LO:  if (fin) nxt = P_WT;
      P_WT:  if (fin) nxt = P_SU;
      P_SU:  if (fin) nxt = IDLE;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      pc <= '0;
      tc <= '0;
      sda_r <= 1'b1;
      wbit <= 1'b0;
      rd <= 1'b0;
      done <= 1'b0;
      rx_bit <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st) begin
        pc <= '0;
        tc <= '0;
      end else if (pc == presc) begin
        pc <= '0;
        tc <= tc + 8'd1;
      end else begin
        pc <= pc + 8'd1;
      end
      done <= (nxt == HOLD && st != HOLD) || (nxt == IDLE && st == P_SU);
      if (st == HOLD && req_valid) begin
        wbit <= req_bit;
        rd <= (req_op == OP_RECV);
      end
      if (st == HOLD && nxt == R_REL) sda_r <= 1'b1;
      if (st == S_SU && nxt == S_HD) sda_r <= 1'b0;
      if (st == B_HD && nxt == B_LO) sda_r <= rd | wbit;
      if (st == P_HD && nxt == P_LO) sda_r <= 1'b0;
      if (st == P_SU && nxt == IDLE) sda_r <= 1'b1;
      if (st == B_HI && nxt == HOLD && rd) rx_bit <= sda_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= 2'b11;
      fcnt[0] <= '0;
      fcnt[1] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (raw[i] == filt[i]) begin
          fcnt[i] <= '0;
        end else if (fcnt[i] == cfg_filter) begin
          filt[i] <= raw[i];
          fcnt[i] <= '0;
        end else begin
          fcnt[i] <= fcnt[i] + 3'd1;
        end
      end
    end
  end

  assign scl_o = !(st inside {HOLD, R_REL, B_HD, B_LO, B_SU, P_HD, P_LO});
  assign sda_o = sda_r;
  assign bus_idle = (st == IDLE);
  assign req_ready = (st == IDLE) || (st == HOLD);
endmodule

// File: rtl/i2c_phase_timer_chk.sv
module i2c_phase_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_o,
  input logic       sda_o,
  input logic       done,
  input logic       req_ready,
  input logic       bus_idle,
  input logic       req_valid,
  input logic [1:0] req_op
);
  assert_start_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $fell(sda_o)) |-> !req_ready);

  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_o) |-> $stable(sda_o));

  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $rose(sda_o)) |-> bus_idle);

  assert_idle_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> (scl_o && sda_o));

  assert_idle_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && req_valid && req_op != 2'd0) |=> (bus_idle && !done));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

bind i2c_phase_timer i2c_phase_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_o(sda_o), .done(done),
  .req_ready(req_ready), .bus_idle(bus_idle), .req_valid(req_valid), .req_op(req_op)
);

// File: tb/tb_i2c_phase_timer.sv
module tb_i2c_phase_timer;
  localparam int CLK_P = 10;
  localparam int SUSTA = 3, HDSTA = 2, SUSTO = 4, SUDAT = 2, LO = 3, HI = 2, REL = 5, HDDAT = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfg_start_stop, cfg_bit, cfg_prescale, cfg_hold;
  logic [2:0] cfg_filter;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic req_bit = 1'b0;
  logic req_ready, done, rx_bit, bus_idle, scl_o, sda_o, scl_i, sda_i;
  logic tgt_sda = 1'b1;
  logic glitch = 1'b0;
  int stretch = 0;
  int rel_age = 0;
  int P = 0, F = 0;
  int checks = 0, errors = 0;
  int k_sfall, k_srise, k_rise, k_fall, k_done;

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) rel_age <= scl_o ? rel_age + 1 : 0;
  assign scl_i = scl_o & ((rel_age > stretch) | (glitch & (rel_age == 1)));
  assign sda_i = sda_o & tgt_sda;

  i2c_phase_timer dut (
    .clk(clk), .rst_n(rst_n), .cfg_start_stop(cfg_start_stop), .cfg_bit(cfg_bit),
    .cfg_prescale(cfg_prescale), .cfg_hold(cfg_hold), .cfg_filter(cfg_filter),
    .req_valid(req_valid), .req_op(req_op), .req_bit(req_bit), .req_ready(req_ready),
    .done(done), .rx_bit(rx_bit), .bus_idle(bus_idle), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_o), .sda_o(sda_o)
  );

  function automatic int dur(int n);
    return (n == 0) ? 1 : n * (P + 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (presc %0d filter %0d)", tag, act, exp, P, F);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic b);
    logic s_prev, c_prev;
    @(negedge clk);
    req_op = op;
    req_bit = b;
    req_valid = 1'b1;
    s_prev = sda_o;
    c_prev = scl_o;
    @(negedge clk);
    req_valid = 1'b0;
    k_sfall = -1; k_srise = -1; k_rise = -1; k_fall = -1; k_done = -1;
    for (int k = 0; k < 4000; k++) begin
      if (k > 0) @(negedge clk);
      if (k_sfall < 0 && s_prev && !sda_o) k_sfall = k;
      if (k_srise < 0 && !s_prev && sda_o) k_srise = k;
      if (k_rise < 0 && !c_prev && scl_o) k_rise = k;
      if (k_fall < 0 && c_prev && !scl_o) k_fall = k;
      s_prev = sda_o;
      c_prev = scl_o;
      if (done) begin
        k_done = k;
        break;
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 3; p++) begin
      for (int f = 0; f < 4; f++) begin
        P = p;
        F = f;
        cfg_start_stop = {8'(SUSTA), 8'(HDSTA), 8'(SUSTO), 8'hA5};
        cfg_bit = {8'(SUDAT), 8'h5A, 8'(LO), 8'(HI)};
        cfg_prescale = {8'hC3, 8'(p), 8'h33, 8'(REL)};
        cfg_hold = {24'hFFFF00, 8'(HDDAT)};
        cfg_filter = 3'(f);
        stretch = 0;
        glitch = 1'b0;
        tgt_sda = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 lines", {scl_o, sda_o}, 2'b11);
        chk("R1 status", {bus_idle, req_ready, done}, 3'b110);

        // R9 ignored send in idle
        begin
          int bad = 0;
          @(negedge clk);
          req_op = 2'd1; req_valid = 1'b1;
          @(negedge clk);
          req_valid = 1'b0;
          for (int k = 0; k < 20; k++) begin
            if (!scl_o || !sda_o || done || !bus_idle) bad++;
            @(negedge clk);
          end
          chk("R9 ignored", bad, 0);
        end

        // R2 start
        do_op(2'd0, 1'b0);
        chk("R2 sda fall", k_sfall, dur(SUSTA));
        chk("R2 scl fall", k_fall, dur(SUSTA) + dur(HDSTA));
        chk("R2 done", k_done, dur(SUSTA) + dur(HDSTA));

        // R3 R4 send 1
        do_op(2'd1, 1'b1);
        chk("R3 sda change", k_srise, dur(HDDAT));
        chk("R3 scl rise", k_rise, dur(HDDAT) + dur(LO) + dur(SUDAT));
        chk("R4 high time", k_done - k_rise, F + 2 + dur(HI));
        chk("R4 fall at done", k_fall, k_done);

        // R3 send 0
        do_op(2'd1, 1'b0);
        chk("R3 sda fall", k_sfall, dur(HDDAT));

        // R6 receive 0 then 1
        tgt_sda = 1'b0;
        do_op(2'd2, 1'b0);
        chk("R6 release", k_srise, dur(HDDAT));
        chk("R6 rx zero", rx_bit, 0);
        tgt_sda = 1'b1;
        do_op(2'd2, 1'b0);
        chk("R6 rx one", rx_bit, 1);

        // R5 stretch
        stretch = 3;
        do_op(2'd1, 1'b0);
        chk("R5 stretched high", k_done - k_rise, 3 + F + 2 + dur(HI));
        stretch = 0;

        // R10 glitch during stretch
        if (f > 0) begin
          stretch = 4;
          glitch = 1'b1;
          do_op(2'd1, 1'b1);
          chk("R10 glitch rejected", k_done - k_rise, 4 + F + 2 + dur(HI));
          stretch = 0;
          glitch = 1'b0;
        end

        // R8 repeated start
        do_op(2'd1, 1'b1);
        do_op(2'd0, 1'b0);
        chk("R8 scl release", k_rise, dur(REL));
        chk("R8 sda fall", k_sfall, dur(REL) + F + 2 + dur(SUSTA));
        chk("R8 done", k_done, dur(REL) + F + 2 + dur(SUSTA) + dur(HDSTA));

        // R7 stop
        do_op(2'd1, 1'b1);
        do_op(2'd3, 1'b0);
        chk("R7 sda low", k_sfall, dur(HDDAT));
        chk("R7 scl rise", k_rise, dur(HDDAT) + dur(SUDAT));
        chk("R7 sda rise", k_srise, dur(HDDAT) + dur(SUDAT) + F + 2 + dur(SUSTO));
        chk("R7 done", k_done, k_srise);
        chk("R7 idle", bus_idle, 1);
        // R11 done lasts one cycle
        @(negedge clk);
        chk("R11 done pulse", done, 0);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule